// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of already-synchronised general-purpose input pins and turns activity on them into interrupt requests. Each pin is configured by three bits spread across three control registers: a sense bit choosing level or edge detection, a dual-edge bit, and a polarity bit. A fourth register enables pins onto the combined interrupt line.

Edge events are held in sticky status bits until software clears them by writing ones to a clear register. Level-sensed pins report the qualified input level directly. Software can read the raw status, or the status after the enable mask. The single `irq` output is high whenever any masked status bit is set.

Access is a simple single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. There is no data stream, so there is no handshake.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register index reads 0, so all pins are disabled and set to falling-edge sense, and `irq` is 0. The edge-history register also resets to 0.
- R2: The four control registers are read and written at these indices: 0 = sense (1 = level, 0 = edge), 1 = dual-edge, 2 = polarity (1 = rising/high, 0 = falling/low), 3 = enable. Each reads back the last value written.
- R3: For a pin whose sense bit is 1, raw status (index 4) follows the input in the same cycle. It equals the pin value when polarity is 1 and the inverted pin value when polarity is 0.
- R4: For a pin in edge mode with its dual-edge bit 0, a rising transition (polarity 1) or a falling transition (polarity 0) sets a sticky raw status bit. An edge is a change relative to the value sampled at the previous clock edge. A transition of the other direction does not set the bit.
- R5: For a pin in edge mode with its dual-edge bit 1, a transition in either direction sets the sticky bit, whatever its polarity bit holds.
- R6: Writing to index 6 clears the latched edge status of each pin whose written bit is 1. Pins written with 0 keep their status. Level-sensed pins are not affected.
- R7: When an edge of a pin and a clear of that pin happen at the same clock edge, the status bit ends up set.
- R8: Index 5 reads raw status AND enable. `irq` is 1 exactly when that value is nonzero.
- R9: Writes to indices 4, 5 and 7 change no register. Index 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Synchronised input pins |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | NPINS | Write data, one bit per pin |
| reg_rdata | output | NPINS | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default of eight pins and the full 3-bit register index. With eight pins, random writes to the three trigger registers put every combination of sense, dual-edge and polarity bits on some pin at the same time. The full index range lets random traffic also reach the two read-only status indices and the unused index 7. Directed steps cover each trigger mode, partial clears, and a clear that collides with an edge on the same pin.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_SENSE  = 3'd0,
    IDX_DUAL   = 3'd1,
    IDX_POL    = 3'd2,
    IDX_ENABLE = 3'd3,
    IDX_RAW    = 3'd4,
    IDX_MASKED = 3'd5,
    IDX_CLEAR  = 3'd6,
    IDX_SPARE  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] level_sel,
  output logic [NPINS-1:0] dual_sel,
  output logic [NPINS-1:0] pol_sel,
  output logic [NPINS-1:0] enable,
  output logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] masked,
  output logic [NPINS-1:0] rdata
);
  reg_idx_e sel;
  assign sel = reg_idx_e'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_sel <= '0;
      dual_sel  <= '0;
      pol_sel   <= '0;
      enable    <= '0;
    end else if (wr) begin
      case (sel)
        IDX_SENSE:  level_sel <= wdata;
        IDX_DUAL:   dual_sel  <= wdata;
        IDX_POL:    pol_sel   <= wdata;
        IDX_ENABLE: enable    <= wdata;
        default:    ;
      endcase
    end
  end

  assign clr    = (wr && sel == IDX_CLEAR) ? wdata : '0;
  assign masked = raw & enable;

  always_comb begin
    case (sel)
      IDX_SENSE:  rdata = level_sel;
      IDX_DUAL:   rdata = dual_sel;
      IDX_POL:    rdata = pol_sel;
      IDX_ENABLE: rdata = enable;
      IDX_RAW:    rdata = raw;
      IDX_MASKED: rdata = masked;
      default:    rdata = '0;
    endcase
  end

  // R9: only a write to a control index may change control state
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (sel == IDX_SENSE || sel == IDX_DUAL || sel == IDX_POL || sel == IDX_ENABLE))
    |=> $stable({level_sel, dual_sel, pol_sel, enable}));
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] level_sel,
  input  logic [NPINS-1:0] dual_sel,
  input  logic [NPINS-1:0] pol_sel,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] raw
);
  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall, hit, latched;

    assign rise = pin_in[g] & ~pin_q[g];
    assign fall = ~pin_in[g] & pin_q[g];
    assign hit  = dual_sel[g] ? (rise | fall) : (pol_sel[g] ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            latched <= 1'b0;
      else if (level_sel[g]) latched <= 1'b0;
      else                   latched <= (latched & ~clr[g]) | hit;
    end

    assign raw[g] = level_sel[g] ? (pol_sel[g] ? pin_in[g] : ~pin_in[g]) : latched;

    // R4: a latched edge persists until cleared
    assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !clr[g] && !level_sel[g]) |=> latched);
    // R6: a clear without a coincident edge empties the latch
    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !hit) |=> !latched);
    // R7: edge beats a simultaneous clear
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr[g] && !level_sel[g]) |=> latched);
  end
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  output logic             irq
);
  logic [NPINS-1:0] level_sel, dual_sel, pol_sel, enable, clr, masked, raw;

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_addr), .wdata(reg_wdata),
    .raw(raw), .level_sel(level_sel), .dual_sel(dual_sel), .pol_sel(pol_sel),
    .enable(enable), .clr(clr), .masked(masked), .rdata(reg_rdata)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level_sel(level_sel),
    .dual_sel(dual_sel), .pol_sel(pol_sel), .clr(clr), .raw(raw)
  );

  assign irq = |masked;

  // R8: the request line needs at least one enabled pin
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enable != '0));
endmodule

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [NP-1:0] reg_wdata = '0;
  logic [NP-1:0] reg_rdata;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic [NP-1:0] m_lvl = '0, m_dual = '0, m_pol = '0, m_en = '0, m_lat = '0, m_prev = '0;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.NPINS(NP)) u_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [NP-1:0] exp_raw(input logic [NP-1:0] p);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++)
      r[i] = m_lvl[i] ? (m_pol[i] ? p[i] : ~p[i]) : m_lat[i];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_read(input logic [2:0] a, input logic [NP-1:0] p);
    case (a)
      3'd0: return m_lvl;
      3'd1: return m_dual;
      3'd2: return m_pol;
      3'd3: return m_en;
      3'd4: return exp_raw(p);
      3'd5: return exp_raw(p) & m_en;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock with the given inputs; model advances at the same edge
  task automatic drive(input logic [NP-1:0] p, input logic w, input logic [2:0] a,
                       input logic [NP-1:0] d);
    logic [NP-1:0] nlat, clrv;
    @(negedge clk);
    pin_in = p; reg_wr = w; reg_addr = a; reg_wdata = d;
    clrv = (w && a == 3'd6) ? d : '0;
    for (int i = 0; i < NP; i++) begin
      logic rise, fall, hit;
      rise = p[i] & ~m_prev[i];
      fall = ~p[i] & m_prev[i];
      hit = m_dual[i] ? (rise | fall) : (m_pol[i] ? rise : fall);
      nlat[i] = m_lvl[i] ? 1'b0 : ((m_lat[i] & ~clrv[i]) | hit);
    end
    @(posedge clk);
    m_lat = nlat;
    m_prev = p;
    if (w) begin
      case (a)
        3'd0: m_lvl = d;
        3'd1: m_dual = d;
        3'd2: m_pol = d;
        3'd3: m_en = d;
        default: ;
      endcase
    end
    #1 reg_wr = 1'b0;
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      reg_addr = a[2:0];
      #0.2;
      check($sformatf("%s idx%0d", tag, a), reg_rdata, exp_read(a[2:0], pin_in));
    end
    check({tag, " irq"}, {7'd0, irq}, {7'd0, |(exp_raw(pin_in) & m_en)});
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 check_all("R1 reset");

    // R2 readback
    drive(8'h00, 1, 3'd0, 8'hA5); drive(8'h00, 1, 3'd1, 8'h3C);
    drive(8'h00, 1, 3'd2, 8'h96); drive(8'h00, 1, 3'd3, 8'h0F);
    check_all("R2 readback");

    // R3 level mode with mixed polarity
    drive(8'h00, 1, 3'd1, 8'h00); drive(8'h00, 1, 3'd3, 8'hFF);
    drive(8'h00, 1, 3'd2, 8'h05); drive(8'h00, 1, 3'd0, 8'h0F);
    drive(8'h03, 0, 3'd0, 8'h00); check_all("R3 level a");
    drive(8'h0C, 0, 3'd0, 8'h00); check_all("R3 level b");

    // R4 single-polarity edges: pins 0-3 rising, 4-7 falling
    drive(8'h00, 1, 3'd0, 8'h00); drive(8'h00, 1, 3'd2, 8'h0F);
    drive(8'h00, 1, 3'd6, 8'hFF); check_all("R4 idle");
    drive(8'hFF, 0, 3'd0, 8'h00); check_all("R4 rise");
    check("R4 rise raw", exp_raw(pin_in), 8'h0F);
    drive(8'h00, 0, 3'd0, 8'h00); check_all("R4 fall");
    check("R4 fall raw", exp_raw(pin_in), 8'hFF);

    // R6 partial clear, then zero clear
    drive(8'h00, 1, 3'd6, 8'h33); check_all("R6 clear");
    drive(8'h00, 1, 3'd6, 8'h00); check_all("R6 zero clear");

    // R5 dual edges
    drive(8'h00, 1, 3'd6, 8'hFF); drive(8'h00, 1, 3'd1, 8'hF0);
    drive(8'h00, 1, 3'd2, 8'h00); drive(8'hAA, 0, 3'd0, 8'h00);
    check_all("R5 dual a");
    drive(8'hFF, 0, 3'd0, 8'h00); check_all("R5 dual b");

    // R7 edge colliding with clear (pin 1 rising, dual)
    drive(8'h00, 1, 3'd1, 8'hFF); drive(8'h00, 1, 3'd6, 8'hFF);
    drive(8'h02, 1, 3'd6, 8'h02); check_all("R7 collide");
    check("R7 bit", exp_raw(pin_in) & 8'h02, 8'h02);

    // R6 clear has no effect on level pins
    drive(8'h02, 1, 3'd0, 8'h0F); drive(8'h02, 1, 3'd6, 8'hFF);
    check_all("R6 level");

    // R8 enable variations
    drive(8'h02, 1, 3'd3, 8'h00); check_all("R8 none");
    drive(8'h02, 1, 3'd3, 8'h80); check_all("R8 one");

    // R9 status-index writes ignored
    drive(8'h02, 1, 3'd4, 8'hFF); drive(8'h02, 1, 3'd5, 8'hFF);
    drive(8'h02, 1, 3'd7, 8'hFF); check_all("R9 ignore");

    // random traffic
    for (int k = 0; k < 600; k++) begin
      logic w;
      w = ($urandom % 3) == 0;
      drive(NP'($urandom), w, 3'($urandom), NP'($urandom));
      check_all("R4/R5/R8 rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule